// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global-Entry Flush

This block caches virtual-page to physical-frame translations for a 32-bit virtual address space with 4 KB pages. It holds a small, fully associative set of entries. Each entry keeps a physical frame number, a write-permission flag, a user-access flag and a global flag. Lookups are combinational. The virtual page number (address bits 31..12) is matched against every valid entry. On a hit, the block returns the physical address, formed from the cached frame and the untouched page offset (bits 11..0), together with the two permission flags.

On a miss, the surrounding logic walks the page tables. It then presents the resulting page-table entry on the fill port. Only present entries are cached. Two invalidation strobes maintain coherence with memory:

- **Base reload.** Raised on any write of the page-table base register. It drops every entry that is not global.
- **Single-page invalidate.** It drops the one entry for a given page, whether or not that entry is global.

The global flag is latched at fill time. A global translation therefore outlives base reloads until it is invalidated by page.

Top module: `xlate_buf`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, and on a miss `lk_pa`, `lk_rw` and `lk_user` are all zero.
- R2: A fill with `fill_en` high and PTE bit 0 (present) set makes lookups of that page hit from the next cycle on. On a hit, `lk_pa` = {PTE bits 31..12, `lk_va` bits 11..0}, `lk_rw` = PTE bit 1 and `lk_user` = PTE bit 2. PTE bit 5 (accessed) and the remaining low bits have no effect.
- R3: A fill whose PTE bit 0 is clear caches nothing. Lookups of that page keep missing, and no existing entry changes.
- R4: A pulse on `base_wr` invalidates every valid entry whose latched global flag (PTE bit 8 at fill) is clear. This holds even when no table contents changed.
- R5: Entries filled with PTE bit 8 set remain valid and unchanged across any number of `base_wr` pulses.
- R6: A pulse on `pg_inv` removes the entry whose page equals `inv_vpn`, including a global one. All other entries are untouched, and an `inv_vpn` that matches nothing changes nothing.
- R7: A fill for a page that is already cached overwrites that same entry, with new frame, flags and global bit. No page is ever held twice, so at most one entry matches a lookup.
- R8: A fill that hits no cached page is placed as follows:
  - If any slot is free, the fill takes the lowest-numbered free slot.
  - If all slots are valid, the fill replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only on such replacements.
- R9: When an invalidation (`base_wr` or `pg_inv`) and a fill arrive in the same cycle, the invalidation is applied first. The filled entry is valid afterwards, even for the page being invalidated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_pa | output | 32 | Translated physical address (zero on miss) |
| lk_rw | output | 1 | Cached write permission of the hit entry |
| lk_user | output | 1 | Cached user-access flag of the hit entry |
| fill_en | input | 1 | Fill strobe |
| fill_vpn | input | 20 | Virtual page number being filled |
| fill_pte | input | 32 | Page-table entry for that page |
| base_wr | input | 1 | Page-table base register was written (drop non-global entries) |
| pg_inv | input | 1 | Single-page invalidate strobe |
| inv_vpn | input | 20 | Virtual page number to invalidate |

## Verification
Lookup results are combinational, so `lk_hit`, `lk_pa` and the flags belong to the same cycle as `lk_va`. Fills and both invalidations become visible to lookups in the cycle after the clock edge that samples the strobe. The bench drives every strobe just after a falling edge and lets one rising edge capture it. It then changes `lk_va` only after the following falling edge and compares a nanosecond later, so each comparison sees post-update contents that have settled. Replacement order is checked purely through which pages still hit after a known sequence of fills and invalidates.

// File: rtl/xlate_pkg.sv
// Package: shared widths, page-table entry bit positions and the entry record
// for the translation buffer. Assumes 32-bit virtual addresses, 4 KB pages.
package xlate_pkg;
    localparam int VA_W     = 32;
    localparam int PG_OFF_W = 12;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PFN_W    = 20;
    localparam int PA_W     = PFN_W + PG_OFF_W;

    // Bit positions inside a page-table entry as presented on the fill port.
    localparam int PTE_P  = 0;
    localparam int PTE_RW = 1;
    localparam int PTE_US = 2;
    localparam int PTE_A  = 5;
    localparam int PTE_G  = 8;
    localparam int PTE_FRAME_LSB = PG_OFF_W;

    // One cached translation.
    typedef struct packed {
        logic             valid;
        logic             glob;
        logic             rw;
        logic             user;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } xl_entry_t;
endpackage

// File: rtl/xlate_cam.sv
// Module: xlate_cam
// Compares one key against N packed tags in parallel. A slot matches only if
// its live bit is set. Purely combinational. Assumes tags are packed with
// slot 0 in the least significant bits.
module xlate_cam #(
    parameter int N = 8,
    parameter int W = 20
) (
    input  logic [N*W-1:0] tags,
    input  logic [N-1:0]   live,
    input  logic [W-1:0]   key,
    output logic [N-1:0]   match
);
    // One comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = live[g] && (tags[g*W +: W] == key);
    end
endmodule

// File: rtl/xlate_victim.sv
// Module: xlate_victim
// Chooses the slot a fill writes. Priority: a slot already holding the page,
// else the lowest free slot, else the round-robin pointer. The pointer moves
// only when it was used. Assumes 'same' is one-hot or zero.
module xlate_victim #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] live,
    input  logic [N-1:0] same,
    input  logic         take,
    output logic [N-1:0] slot_oh
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr_q;
    logic [N-1:0]  free_oh;
    logic [N-1:0]  ptr_oh;
    logic          any_free;
    logic          use_ptr;
    logic          found;

    // Lowest-index free slot as a one-hot vector.
    always_comb begin
        free_oh = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!live[i] && !found) begin
                free_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    // Decode the round-robin pointer into a one-hot vector.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ptr_oh[i] = (ptr_q == PW'(i));
        end
    end

    assign any_free = ~&live;
    assign use_ptr  = take && !(|same) && !any_free;

    // Final slot choice by priority.
    always_comb begin
        if (|same) begin
            slot_oh = same;
        end else if (any_free) begin
            slot_oh = free_oh;
        end else begin
            slot_oh = ptr_oh;
        end
    end

    // Advance the pointer, wrapping, when a replacement used it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (use_ptr) begin
            ptr_q <= (ptr_q == PW'(N - 1)) ? '0 : ptr_q + PW'(1);
        end
    end
endmodule

// File: rtl/xlate_read.sv
// Module: xlate_read
// Returns the frame and flags of the selected slot by AND-OR selection.
// Outputs are zero when nothing is selected. Assumes 'sel' is one-hot or zero.
module xlate_read #(
    parameter int N = 8,
    parameter int W = 20
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] frames,
    input  logic [N-1:0]   rw_vec,
    input  logic [N-1:0]   us_vec,
    output logic [W-1:0]   frame,
    output logic           rw,
    output logic           us
);
    // OR together the fields of the selected slots.
    always_comb begin
        frame = '0;
        rw    = 1'b0;
        us    = 1'b0;
        for (int i = 0; i < N; i++) begin
            frame = frame | (frames[i*W +: W] & {W{sel[i]}});
            rw    = rw | (rw_vec[i] & sel[i]);
            us    = us | (us_vec[i] & sel[i]);
        end
    end
endmodule

// File: rtl/xlate_buf.sv
// Module: xlate_buf (top)
// Fully associative translation buffer.
//   Lookup:      combinational.
//   Fill:        accepted only for present entries.
//   base_wr:     removes non-global entries.
//   pg_inv:      removes one page, global or not.
//   Same cycle:  the invalidation is applied before the fill.
// Assumes 4 KB pages and a synchronous active-low reset.
module xlate_buf
    import xlate_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_rw,
    output logic             lk_user,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [31:0]      fill_pte,
    input  logic             base_wr,
    input  logic             pg_inv,
    input  logic [VPN_W-1:0] inv_vpn
);
    xl_entry_t tab_q [ENTRIES];

    logic [ENTRIES-1:0]       valid_q;
    logic [ENTRIES-1:0]       glob_q;
    logic [ENTRIES-1:0]       rw_vec;
    logic [ENTRIES-1:0]       us_vec;
    logic [ENTRIES*VPN_W-1:0] vpn_flat;
    logic [ENTRIES*PFN_W-1:0] pfn_flat;

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] inv_match;
    logic [ENTRIES-1:0] kill_vec;
    logic [ENTRIES-1:0] live_after;
    logic [ENTRIES-1:0] same_vec;
    logic [ENTRIES-1:0] slot_oh;
    logic               fill_go;
    xl_entry_t          new_ent;
    logic [PFN_W-1:0]   hit_pfn;
    logic               pte_unused;

    // Flatten the table fields for the match and read blocks.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_q[g]                 = tab_q[g].valid;
        assign glob_q[g]                  = tab_q[g].glob;
        assign rw_vec[g]                  = tab_q[g].rw;
        assign us_vec[g]                  = tab_q[g].user;
        assign vpn_flat[g*VPN_W +: VPN_W] = tab_q[g].vpn;
        assign pfn_flat[g*PFN_W +: PFN_W] = tab_q[g].pfn;
    end

    // Lookup match against valid entries.
    xlate_cam #(.N(ENTRIES), .W(VPN_W)) cam_lk_i (
        .tags  (vpn_flat),
        .live  (valid_q),
        .key   (lk_va[VA_W-1:PG_OFF_W]),
        .match (hit_vec)
    );

    // Single-page invalidate match.
    xlate_cam #(.N(ENTRIES), .W(VPN_W)) cam_inv_i (
        .tags  (vpn_flat),
        .live  (valid_q),
        .key   (inv_vpn),
        .match (inv_match)
    );

    // Slots removed this cycle: non-global on a base reload, the matching page on pg_inv.
    assign kill_vec   = ({ENTRIES{base_wr}} & valid_q & ~glob_q)
                      | ({ENTRIES{pg_inv}} & inv_match);
    assign live_after = valid_q & ~kill_vec;

    // Duplicate check for the fill, against contents after invalidation.
    xlate_cam #(.N(ENTRIES), .W(VPN_W)) cam_fill_i (
        .tags  (vpn_flat),
        .live  (live_after),
        .key   (fill_vpn),
        .match (same_vec)
    );

    assign fill_go = fill_en && fill_pte[PTE_P];

    // Slot choice for the fill.
    xlate_victim #(.N(ENTRIES)) victim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live_after),
        .same    (same_vec),
        .take    (fill_go),
        .slot_oh (slot_oh)
    );

    // Decode the incoming page-table entry into a cache record.
    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.glob  = fill_pte[PTE_G];
        new_ent.rw    = fill_pte[PTE_RW];
        new_ent.user  = fill_pte[PTE_US];
        new_ent.vpn   = fill_vpn;
        new_ent.pfn   = fill_pte[PTE_FRAME_LSB +: PFN_W];
    end

    // Entry bits not cached (accessed, reserved, software).
    assign pte_unused = ^{fill_pte[11:9], fill_pte[7:6], fill_pte[PTE_A], fill_pte[4:3]};

    // Table update: the fill wins over an invalidation of the same slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_go && slot_oh[i]) begin
                    tab_q[i] <= new_ent;
                end else if (kill_vec[i]) begin
                    tab_q[i].valid <= 1'b0;
                end
            end
        end
    end

    // Read out the frame and flags of the hit entry.
    xlate_read #(.N(ENTRIES), .W(PFN_W)) read_i (
        .sel    (hit_vec),
        .frames (pfn_flat),
        .rw_vec (rw_vec),
        .us_vec (us_vec),
        .frame  (hit_pfn),
        .rw     (lk_rw),
        .us     (lk_user)
    );

    assign lk_hit = |hit_vec;
    assign lk_pa  = lk_hit ? {hit_pfn, lk_va[PG_OFF_W-1:0]} : '0;
endmodule

// File: rtl/xlate_buf_chk.sv
// Module: xlate_buf_chk
// Property checker bound to xlate_buf. It observes the strobes and the
// flattened table state. Assumes the synchronous active-low reset of the
// top module.
module xlate_buf_chk #(
    parameter int N = 8,
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fill_en,
    input logic         fill_present,
    input logic [W-1:0] fill_vpn,
    input logic         base_wr,
    input logic         pg_inv,
    input logic [W-1:0] inv_vpn,
    input logic [N-1:0] valid_q,
    input logic [N-1:0] glob_q,
    input logic [N*W-1:0] vpn_flat,
    input logic [N-1:0] hit_vec
);
    logic [W-1:0] fill_vpn_q;
    logic [W-1:0] inv_vpn_q;
    logic         fill_cached;
    logic         inv_cached;

    // Remember the last pages named by the fill and invalidate ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_vpn_q <= '0;
            inv_vpn_q  <= '0;
        end else begin
            fill_vpn_q <= fill_vpn;
            inv_vpn_q  <= inv_vpn;
        end
    end

    // Is each remembered page currently held by a valid entry?
    always_comb begin
        fill_cached = 1'b0;
        inv_cached  = 1'b0;
        for (int i = 0; i < N; i++) begin
            fill_cached = fill_cached | (valid_q[i] && vpn_flat[i*W +: W] == fill_vpn_q);
            inv_cached  = inv_cached  | (valid_q[i] && vpn_flat[i*W +: W] == inv_vpn_q);
        end
    end

    p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_nonpresent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_present && !base_wr && !pg_inv) |=> $stable(valid_q));

    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !fill_en) |=> ((valid_q & ~glob_q) == '0));

    p_global_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !pg_inv && !fill_en) |=> (valid_q == $past(valid_q & glob_q)));

    p_page_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_inv && !fill_en) |=> !inv_cached);

    p_fill_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_present) |=> fill_cached);
endmodule

bind xlate_buf xlate_buf_chk #(.N(ENTRIES), .W(xlate_pkg::VPN_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_en      (fill_en),
    .fill_present (fill_pte[0]),
    .fill_vpn     (fill_vpn),
    .base_wr      (base_wr),
    .pg_inv       (pg_inv),
    .inv_vpn      (inv_vpn),
    .valid_q      (valid_q),
    .glob_q       (glob_q),
    .vpn_flat     (vpn_flat),
    .hit_vec      (hit_vec)
);

// File: tb/xlate_buf_tb.sv
// Bench for xlate_buf. Inputs are driven after falling edges. Lookups are
// compared 1 ns after the falling edge that follows the capturing rising edge.
module xlate_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_va;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        lk_rw;
    logic        lk_user;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [31:0] fill_pte;
    logic        base_wr;
    logic        pg_inv;
    logic [19:0] inv_vpn;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xlate_buf dut_i (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .lk_rw(lk_rw), .lk_user(lk_user), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_pte(fill_pte), .base_wr(base_wr), .pg_inv(pg_inv), .inv_vpn(inv_vpn)
    );

    // Page numbers and frames used by the sweeps.
    function automatic logic [19:0] vpn_of(int k);
        return 20'h00040 + 20'(k * 37);
    endfunction

    function automatic logic [19:0] pfn_of(logic [19:0] v);
        return v ^ 20'hA5C3B;
    endfunction

    // Layout: frame[31:12], global[8], accessed[5], user[2], rw[1], present[0].
    function automatic logic [31:0] mk_pte(logic [19:0] pfn, logic g, logic us, logic rw, logic p);
        return {pfn, 3'b000, g, 2'b00, 1'b1, 2'b00, us, rw, p};
    endfunction

    // Advance one cycle: the rising edge captures the strobes.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_fill(logic [19:0] v, logic [31:0] pte);
        fill_en = 1'b1; fill_vpn = v; fill_pte = pte;
        step();
        fill_en = 1'b0;
    endtask

    task automatic do_flush();
        base_wr = 1'b1;
        step();
        base_wr = 1'b0;
    endtask

    task automatic do_inv(logic [19:0] v);
        pg_inv = 1'b1; inv_vpn = v;
        step();
        pg_inv = 1'b0;
    endtask

    // Compare one lookup. A miss expects zero address and flags.
    task automatic look(string req, logic [19:0] v, logic [11:0] off,
                        logic e_hit, logic [19:0] e_pfn, logic e_rw, logic e_us);
        logic [34:0] got, exp;
        lk_va = {v, off};
        #1;
        got = {lk_hit, lk_pa, lk_rw, lk_user};
        exp = e_hit ? {1'b1, e_pfn, off, e_rw, e_us} : 35'd0;
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s va=%h got hit=%b pa=%h rw=%b us=%b expected hit=%b pa=%h rw=%b us=%b",
                     req, {v, off}, got[34], got[33:2], got[1], got[0],
                     exp[34], exp[33:2], exp[1], exp[0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run is counted as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; lk_va = '0; fill_en = 1'b0; fill_vpn = '0; fill_pte = '0;
        base_wr = 1'b0; pg_inv = 1'b0; inv_vpn = '0;
        @(negedge clk); step(); step();
        rst_n = 1'b1;

        // R1: empty after reset.
        for (int k = 0; k < 8; k++) look("R1", vpn_of(k), 12'h123, 1'b0, '0, 1'b0, 1'b0);

        // R3: non-present fill caches nothing.
        do_fill(vpn_of(0), mk_pte(pfn_of(vpn_of(0)), 1'b1, 1'b1, 1'b1, 1'b0));
        look("R3", vpn_of(0), 12'h000, 1'b0, '0, 1'b0, 1'b0);

        // R2: fill 8 pages with swept flags. Page k is global when k>=4.
        for (int k = 0; k < 8; k++)
            do_fill(vpn_of(k), mk_pte(pfn_of(vpn_of(k)), k[2], k[1], k[0], 1'b1));
        for (int k = 0; k < 8; k++) begin
            look("R2", vpn_of(k), 12'h000, 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);
            look("R2", vpn_of(k), 12'hFFF, 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);
            look("R2", vpn_of(k), 12'(k * 12'h111), 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);
        end

        // R3: a non-present fill of a new page when full disturbs nothing.
        do_fill(vpn_of(9), mk_pte(20'h1, 1'b0, 1'b0, 1'b0, 1'b0));
        look("R3", vpn_of(9), 12'h0, 1'b0, '0, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) look("R3", vpn_of(k), 12'h8, 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);

        // R4/R5: a base reload keeps only the global pages.
        do_flush();
        for (int k = 0; k < 8; k++)
            look(k >= 4 ? "R5" : "R4", vpn_of(k), 12'h44, k >= 4, k >= 4 ? pfn_of(vpn_of(k)) : '0,
                 k >= 4 ? k[0] : 1'b0, k >= 4 ? k[1] : 1'b0);
        do_flush();
        for (int k = 4; k < 8; k++) look("R5", vpn_of(k), 12'h45, 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);

        // R6: an unmatched page invalidate does nothing; a matched one removes a global page.
        do_inv(vpn_of(12));
        for (int k = 4; k < 8; k++) look("R6", vpn_of(k), 12'h46, 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);
        do_inv(vpn_of(4));
        look("R6", vpn_of(4), 12'h47, 1'b0, '0, 1'b0, 1'b0);
        for (int k = 5; k < 8; k++) look("R6", vpn_of(k), 12'h47, 1'b1, pfn_of(vpn_of(k)), k[0], k[1]);

        // R7: a refill overwrites in place; the latched global bit follows the latest fill.
        do_fill(vpn_of(5), mk_pte(20'h0BEEF, 1'b0, 1'b1, 1'b0, 1'b1));
        look("R7", vpn_of(5), 12'h9, 1'b1, 20'h0BEEF, 1'b0, 1'b1);
        do_flush();
        look("R7", vpn_of(5), 12'h9, 1'b0, '0, 1'b0, 1'b0);
        look("R7", vpn_of(6), 12'h9, 1'b1, pfn_of(vpn_of(6)), 1'b0, 1'b1);

        // R8: replacement order from a clean reset.
        rst_n = 1'b0; step(); rst_n = 1'b1;
        for (int k = 0; k < 9; k++)
            do_fill(vpn_of(k), mk_pte(pfn_of(vpn_of(k)), 1'b0, 1'b0, 1'b1, 1'b1));
        look("R8", vpn_of(0), 12'h1, 1'b0, '0, 1'b0, 1'b0);
        for (int k = 1; k < 9; k++) look("R8", vpn_of(k), 12'h1, 1'b1, pfn_of(vpn_of(k)), 1'b1, 1'b0);
        do_fill(vpn_of(9), mk_pte(pfn_of(vpn_of(9)), 1'b0, 1'b0, 1'b1, 1'b1));
        look("R8", vpn_of(1), 12'h2, 1'b0, '0, 1'b0, 1'b0);
        do_inv(vpn_of(5));
        do_fill(vpn_of(10), mk_pte(pfn_of(vpn_of(10)), 1'b0, 1'b0, 1'b1, 1'b1));
        for (int k = 2; k < 11; k++)
            look("R8", vpn_of(k), 12'h3, k != 5, k != 5 ? pfn_of(vpn_of(k)) : '0, k != 5, 1'b0);
        do_fill(vpn_of(11), mk_pte(pfn_of(vpn_of(11)), 1'b0, 1'b0, 1'b1, 1'b1));
        look("R8", vpn_of(2), 12'h4, 1'b0, '0, 1'b0, 1'b0);
        look("R8", vpn_of(3), 12'h4, 1'b1, pfn_of(vpn_of(3)), 1'b1, 1'b0);
        look("R8", vpn_of(11), 12'h4, 1'b1, pfn_of(vpn_of(11)), 1'b1, 1'b0);

        // R9: an invalidation and a fill in the same cycle leave the fill in place.
        base_wr = 1'b1; fill_en = 1'b1; fill_vpn = vpn_of(20);
        fill_pte = mk_pte(20'h12345, 1'b0, 1'b1, 1'b1, 1'b1);
        step();
        base_wr = 1'b0; fill_en = 1'b0;
        look("R9", vpn_of(20), 12'hABC, 1'b1, 20'h12345, 1'b1, 1'b1);
        look("R9", vpn_of(3), 12'hABC, 1'b0, '0, 1'b0, 1'b0);
        pg_inv = 1'b1; inv_vpn = vpn_of(20); fill_en = 1'b1; fill_vpn = vpn_of(20);
        fill_pte = mk_pte(20'h54321, 1'b1, 1'b0, 1'b1, 1'b1);
        step();
        pg_inv = 1'b0; fill_en = 1'b0;
        look("R9", vpn_of(20), 12'h5, 1'b1, 20'h54321, 1'b1, 1'b0);

        finish_run();
    end
endmodule